// File: doc/BRIEF.md
# Sequential Instruction Prefetch Buffer

This block sits beside a level-one instruction cache and turns each cache miss into a demand fetch plus a speculative fetch of the next sequential block. The demand block is handed to the cache as a fill. The speculative block is parked in a single-entry side buffer. When a later cache miss finds its block in that buffer, the fill comes straight from the buffer with no trip to the unified second-level cache, and the block after it is fetched in turn.

Every miss probes the buffer. A miss that matches neither the parked block nor the block in flight drops the parked block and restarts the sequence at the new address. A miss to the block currently in flight waits for that response instead of sending a second request. Demand and prefetch traffic share one request port toward the second-level cache, and demand traffic always goes first. A kind bit on the request is echoed on the response to tell the two apart. All addresses on the ports are block addresses. A block is `BLK_BYTES` bytes long (32 by default).

Top module: `isb_prefetch`

## Requirements
- R1: A miss to block b that matches neither the parked block nor the pending block sends exactly one request with kind bit 0 (demand) for b. The fill for b, carrying the response data, appears in the cycle after the demand response. `miss_ready_o` stays low from acceptance until that fill.
- R2: After a demand request for b, a request with kind bit 1 (prefetch) is sent for block b+1, taken modulo 2^BA_W, so that the highest block wraps to block 0.
- R3: A miss that matches a valid parked block is filled in the cycle after acceptance with the parked data, and no demand request is sent.
- R4: When the parked block or a waited-for prefetch is handed to the cache, a prefetch for the block after it is requested next.
- R5: A miss that matches neither entry discards the parked block, so a later miss to the discarded block sends a demand request.
- R6: A miss that matches the block whose prefetch is pending sends no demand request. It is filled, with the prefetch response data, in the cycle after that response.
- R7: When demand and prefetch requests both wait for the port, the demand request is presented first. A request held while `l2_req_ready_i` is low keeps its kind and address.
- R8: A one-cycle `flush_i` clears the valid flag, the pending flag and the address of the buffer, so a later miss to the flushed block sends a demand request.
- R9: A prefetch response whose buffer entry was discarded while it was in flight is dropped and never used to fill a later miss.
- R10: At most one prefetch request is outstanding at the port. A new prefetch waits until the previous prefetch response has returned.
- R11: After reset there is no request and no fill, and `miss_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Clears the side buffer |
| miss_valid_i | input | 1 | Cache reports a miss |
| miss_blk_i | input | BA_W | Block address of the miss |
| miss_ready_o | output | 1 | Miss accepted when high together with miss_valid_i |
| fill_valid_o | output | 1 | One-cycle fill strobe to the cache |
| fill_blk_o | output | BA_W | Block address of the fill |
| fill_data_o | output | DATA_W | Block contents of the fill |
| l2_req_valid_o | output | 1 | Request to second-level cache |
| l2_req_ready_i | input | 1 | Request taken |
| l2_req_pf_o | output | 1 | Request kind: 1 prefetch, 0 demand |
| l2_req_blk_o | output | BA_W | Requested block address |
| l2_rsp_valid_i | input | 1 | Response strobe |
| l2_rsp_pf_i | input | 1 | Echoed request kind |
| l2_rsp_blk_i | input | BA_W | Block address of the response |
| l2_rsp_data_i | input | DATA_W | Block contents of the response |

## Verification
The main path is tried with a cold miss, a miss that hits the parked block, a miss to the block still in flight, and a miss far from the current sequence. These tell apart the demand-only fill, the buffer fill without a request, the wait that avoids a duplicate request, and the discard-and-restart case. Holding the port not-ready while both request kinds wait separates correct priority from arrival order. Returning a prefetch only after its entry was discarded shows whether stale data can leak into a later fill. A miss at the highest block checks that the next-block address wraps to zero.

// File: rtl/isb_pkg.sv
package isb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DREQ  = 2'd1,
      ST_DWAIT = 2'd2,
      ST_PWAIT = 2'd3
   } isb_state_e;

endpackage

// File: rtl/isb_sbuf.sv
module isb_sbuf #(
   parameter int BA_W   = 27,
   parameter int DATA_W = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic [BA_W-1:0]   probe_blk_i,
   output logic              probe_hit_o,
   output logic              probe_pend_o,
   output logic [DATA_W-1:0] data_o,
   input  logic              arm_i,
   input  logic [BA_W-1:0]   arm_blk_i,
   output logic              pf_req_o,
   output logic [BA_W-1:0]   pf_blk_o,
   input  logic              pf_gnt_i,
   input  logic              rsp_valid_i,
   input  logic              rsp_pf_i,
   input  logic [BA_W-1:0]   rsp_blk_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic              pf_done_o
);

   logic              valid_q;
   logic              pend_q;
   logic              iss_q;
   logic              out_q;
   logic [BA_W-1:0]   blk_q;
   logic [DATA_W-1:0] data_q;
   logic              pf_rsp;

   assign pf_rsp       = rsp_valid_i & rsp_pf_i;
   assign probe_hit_o  = valid_q & (probe_blk_i == blk_q);
   assign probe_pend_o = pend_q & (probe_blk_i == blk_q);
   assign data_o       = data_q;
   assign pf_req_o     = pend_q & ~iss_q & ~out_q;
   assign pf_blk_o     = blk_q;
   assign pf_done_o    = pf_rsp & pend_q & iss_q & (rsp_blk_i == blk_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else if (pf_gnt_i) begin
         out_q <= 1'b1;
      end else if (pf_rsp) begin
         out_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pend_q  <= 1'b0;
         iss_q   <= 1'b0;
         blk_q   <= '0;
         data_q  <= '0;
      end else if (flush_i) begin
         valid_q <= 1'b0;
         pend_q  <= 1'b0;
         iss_q   <= 1'b0;
         blk_q   <= '0;
      end else if (arm_i) begin
         valid_q <= 1'b0;
         pend_q  <= 1'b1;
         iss_q   <= 1'b0;
         blk_q   <= arm_blk_i;
      end else begin
         if (pf_gnt_i) begin
            iss_q <= 1'b1;
         end
         if (pf_done_o) begin
            valid_q <= 1'b1;
            pend_q  <= 1'b0;
            iss_q   <= 1'b0;
            data_q  <= rsp_data_i;
         end
      end
   end

   AST_PF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pf_gnt_i |-> !out_q) else $error("second prefetch while one in flight"); // R10

   AST_BUF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_q && pend_q)) else $error("entry both parked and pending"); // R4

   AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_rsp && !iss_q && !valid_q) |=> !valid_q) else $error("stale prefetch kept"); // R9

   AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (!valid_q && !pend_q && blk_q == '0)) else $error("flush left state"); // R8

endmodule

// File: rtl/isb_ctrl.sv
module isb_ctrl
   import isb_pkg::*;
#(
   parameter int BA_W   = 27,
   parameter int DATA_W = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              miss_valid_i,
   input  logic [BA_W-1:0]   miss_blk_i,
   output logic              miss_ready_o,
   output logic [BA_W-1:0]   probe_blk_o,
   input  logic              probe_hit_i,
   input  logic              probe_pend_i,
   input  logic [DATA_W-1:0] sb_data_i,
   output logic              arm_o,
   output logic [BA_W-1:0]   arm_blk_o,
   input  logic              pf_done_i,
   input  logic              rsp_valid_i,
   input  logic              rsp_pf_i,
   input  logic [BA_W-1:0]   rsp_blk_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic              dem_req_o,
   output logic [BA_W-1:0]   dem_blk_o,
   input  logic              dem_gnt_i,
   output logic              fill_valid_o,
   output logic [BA_W-1:0]   fill_blk_o,
   output logic [DATA_W-1:0] fill_data_o
);

   isb_state_e        state_q, state_d;
   logic [BA_W-1:0]   cur_q;
   logic              take;
   logic              dem_back;
   logic              fill_set;
   logic [BA_W-1:0]   fill_blk_d;
   logic [DATA_W-1:0] fill_data_d;
   logic              fill_v_q;
   logic [BA_W-1:0]   fill_blk_q;
   logic [DATA_W-1:0] fill_data_q;

   assign miss_ready_o = (state_q == ST_IDLE) & ~flush_i & ~(rsp_valid_i & rsp_pf_i);
   assign take         = miss_valid_i & miss_ready_o;
   assign probe_blk_o  = (state_q == ST_IDLE) ? miss_blk_i : cur_q;
   assign dem_req_o    = (state_q == ST_DREQ);
   assign dem_blk_o    = cur_q;
   assign dem_back     = rsp_valid_i & ~rsp_pf_i & (rsp_blk_i == cur_q);

   always_comb begin
      state_d     = state_q;
      arm_o       = 1'b0;
      arm_blk_o   = miss_blk_i + BA_W'(1);
      fill_set    = 1'b0;
      fill_blk_d  = cur_q;
      fill_data_d = rsp_data_i;
      unique case (state_q)
         ST_IDLE: begin
            if (take) begin
               if (probe_hit_i) begin
                  arm_o       = 1'b1;
                  fill_set    = 1'b1;
                  fill_blk_d  = miss_blk_i;
                  fill_data_d = sb_data_i;
               end else if (probe_pend_i) begin
                  state_d = ST_PWAIT;
               end else begin
                  arm_o   = 1'b1;
                  state_d = ST_DREQ;
               end
            end
         end
         ST_DREQ: begin
            if (dem_gnt_i) state_d = ST_DWAIT;
         end
         ST_DWAIT: begin
            if (dem_back) begin
               fill_set = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         ST_PWAIT: begin
            if (pf_done_i) begin
               arm_o     = 1'b1;
               arm_blk_o = cur_q + BA_W'(1);
               fill_set  = 1'b1;
               state_d   = ST_IDLE;
            end else if (flush_i) begin
               state_d = ST_DREQ;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cur_q       <= '0;
         fill_v_q    <= 1'b0;
         fill_blk_q  <= '0;
         fill_data_q <= '0;
      end else begin
         state_q  <= state_d;
         fill_v_q <= fill_set;
         if (take) cur_q <= miss_blk_i;
         if (fill_set) begin
            fill_blk_q  <= fill_blk_d;
            fill_data_q <= fill_data_d;
         end
      end
   end

   assign fill_valid_o = fill_v_q;
   assign fill_blk_o   = fill_blk_q;
   assign fill_data_o  = fill_data_q;

   AST_HIT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (take && probe_hit_i) |=> (fill_valid_o && state_q == ST_IDLE)) else $error("buffer hit not filled"); // R3

   AST_WAIT_NO_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PWAIT && !flush_i) |=> (state_q != ST_DREQ)) else $error("duplicate demand"); // R6

endmodule

// File: rtl/isb_l2mux.sv
module isb_l2mux #(
   parameter int BA_W = 27
) (
   input  logic            dem_req_i,
   input  logic [BA_W-1:0] dem_blk_i,
   input  logic            pf_req_i,
   input  logic [BA_W-1:0] pf_blk_i,
   input  logic            ready_i,
   output logic            valid_o,
   output logic            pf_o,
   output logic [BA_W-1:0] blk_o,
   output logic            dem_gnt_o,
   output logic            pf_gnt_o
);

   assign valid_o   = dem_req_i | pf_req_i;
   assign pf_o      = ~dem_req_i;
   assign blk_o     = dem_req_i ? dem_blk_i : pf_blk_i;
   assign dem_gnt_o = dem_req_i & ready_i;
   assign pf_gnt_o  = ~dem_req_i & pf_req_i & ready_i;

endmodule

// File: rtl/isb_prefetch.sv
module isb_prefetch #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 32,
   localparam int OFF_W    = $clog2(BLK_BYTES),
   localparam int BA_W     = ADDR_W - OFF_W,
   localparam int DATA_W   = 8 * BLK_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              miss_valid_i,
   input  logic [BA_W-1:0]   miss_blk_i,
   output logic              miss_ready_o,
   output logic              fill_valid_o,
   output logic [BA_W-1:0]   fill_blk_o,
   output logic [DATA_W-1:0] fill_data_o,
   output logic              l2_req_valid_o,
   input  logic              l2_req_ready_i,
   output logic              l2_req_pf_o,
   output logic [BA_W-1:0]   l2_req_blk_o,
   input  logic              l2_rsp_valid_i,
   input  logic              l2_rsp_pf_i,
   input  logic [BA_W-1:0]   l2_rsp_blk_i,
   input  logic [DATA_W-1:0] l2_rsp_data_i
);

   initial begin
      assert (BLK_BYTES >= 4 && (BLK_BYTES & (BLK_BYTES - 1)) == 0)
         else $error("BLK_BYTES must be a power of two, at least 4");
      assert (ADDR_W > OFF_W + 1)
         else $error("ADDR_W too small for block size");
   end

   logic [BA_W-1:0]   probe_blk;
   logic              probe_hit, probe_pend;
   logic [DATA_W-1:0] sb_data;
   logic              arm;
   logic [BA_W-1:0]   arm_blk;
   logic              pf_req, pf_gnt, pf_done;
   logic [BA_W-1:0]   pf_blk;
   logic              dem_req, dem_gnt;
   logic [BA_W-1:0]   dem_blk;

   isb_ctrl #(.BA_W(BA_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .miss_valid_i(miss_valid_i), .miss_blk_i(miss_blk_i), .miss_ready_o(miss_ready_o),
      .probe_blk_o(probe_blk), .probe_hit_i(probe_hit), .probe_pend_i(probe_pend),
      .sb_data_i(sb_data), .arm_o(arm), .arm_blk_o(arm_blk), .pf_done_i(pf_done),
      .rsp_valid_i(l2_rsp_valid_i), .rsp_pf_i(l2_rsp_pf_i),
      .rsp_blk_i(l2_rsp_blk_i), .rsp_data_i(l2_rsp_data_i),
      .dem_req_o(dem_req), .dem_blk_o(dem_blk), .dem_gnt_i(dem_gnt),
      .fill_valid_o(fill_valid_o), .fill_blk_o(fill_blk_o), .fill_data_o(fill_data_o)
   );

   isb_sbuf #(.BA_W(BA_W), .DATA_W(DATA_W)) u_sbuf (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .probe_blk_i(probe_blk), .probe_hit_o(probe_hit), .probe_pend_o(probe_pend),
      .data_o(sb_data), .arm_i(arm), .arm_blk_i(arm_blk),
      .pf_req_o(pf_req), .pf_blk_o(pf_blk), .pf_gnt_i(pf_gnt),
      .rsp_valid_i(l2_rsp_valid_i), .rsp_pf_i(l2_rsp_pf_i),
      .rsp_blk_i(l2_rsp_blk_i), .rsp_data_i(l2_rsp_data_i), .pf_done_o(pf_done)
   );

   isb_l2mux #(.BA_W(BA_W)) u_mux (
      .dem_req_i(dem_req), .dem_blk_i(dem_blk), .pf_req_i(pf_req), .pf_blk_i(pf_blk),
      .ready_i(l2_req_ready_i), .valid_o(l2_req_valid_o), .pf_o(l2_req_pf_o),
      .blk_o(l2_req_blk_o), .dem_gnt_o(dem_gnt), .pf_gnt_o(pf_gnt)
   );

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_req_valid_o && !l2_req_pf_o && !l2_req_ready_i)
      |=> (l2_req_valid_o && !l2_req_pf_o && $stable(l2_req_blk_o))) else $error("demand not held"); // R7

   AST_FILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid_o |-> ($past(miss_valid_i && miss_ready_o) || $past(l2_rsp_valid_i))) else $error("fill without cause"); // R1

endmodule

// File: tb/sim_isb_prefetch.sv
`timescale 1ns/1ps
module sim_isb_prefetch;

   localparam int BA_W   = 27;
   localparam int DATA_W = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush_i = 1'b0;
   logic              miss_valid_i = 1'b0;
   logic [BA_W-1:0]   miss_blk_i = '0;
   logic              miss_ready_o;
   logic              fill_valid_o;
   logic [BA_W-1:0]   fill_blk_o;
   logic [DATA_W-1:0] fill_data_o;
   logic              l2_req_valid_o;
   logic              l2_req_ready_i = 1'b1;
   logic              l2_req_pf_o;
   logic [BA_W-1:0]   l2_req_blk_o;
   logic              l2_rsp_valid_i = 1'b0;
   logic              l2_rsp_pf_i = 1'b0;
   logic [BA_W-1:0]   l2_rsp_blk_i = '0;
   logic [DATA_W-1:0] l2_rsp_data_i = '0;

   isb_prefetch u0 (.*);

   always #10 clk = ~clk;

   int total = 0;
   int bad = 0;
   int req_cnt = 0;
   int req_rd = 0;
   logic            req_pf_log [64];
   logic [BA_W-1:0] req_blk_log [64];
   int fill_cnt = 0;
   int fill_rd = 0;
   logic [BA_W-1:0]   last_fill_blk;
   logic [DATA_W-1:0] last_fill_data;

   function automatic logic [DATA_W-1:0] blk_data(input logic [BA_W-1:0] b);
      return {8{32'(b) ^ 32'h5A5A_1234}};
   endfunction

   always @(negedge clk) begin
      if (l2_req_valid_o && l2_req_ready_i && req_cnt < 64) begin
         req_pf_log[req_cnt]  = l2_req_pf_o;
         req_blk_log[req_cnt] = l2_req_blk_o;
         req_cnt++;
      end
      if (fill_valid_o) begin
         last_fill_blk  = fill_blk_o;
         last_fill_data = fill_data_o;
         fill_cnt++;
      end
   end

   task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_miss(input logic [BA_W-1:0] b);
      @(posedge clk); #2;
      miss_valid_i = 1'b1;
      miss_blk_i   = b;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (miss_ready_o) break;
      end
      @(posedge clk); #2;
      miss_valid_i = 1'b0;
   endtask

   task automatic respond(input logic pf, input logic [BA_W-1:0] b);
      @(posedge clk); #2;
      l2_rsp_valid_i = 1'b1;
      l2_rsp_pf_i    = pf;
      l2_rsp_blk_i   = b;
      l2_rsp_data_i  = blk_data(b);
      @(posedge clk); #2;
      l2_rsp_valid_i = 1'b0;
   endtask

   task automatic wait_req(input logic pf, input logic [BA_W-1:0] b, input string tag);
      for (int i = 0; i < 40; i++) begin
         if (req_cnt > req_rd) break;
         @(negedge clk); #1;
      end
      if (req_cnt > req_rd) begin
         check(req_pf_log[req_rd] == pf && req_blk_log[req_rd] == b, tag,
               {36'(req_pf_log[req_rd]), 1'b0, req_blk_log[req_rd]}, {36'(pf), 1'b0, b});
         req_rd++;
      end else begin
         check(1'b0, tag, 64'd0, {36'(pf), 1'b0, b});
      end
   endtask

   task automatic wait_fill(input logic [BA_W-1:0] b, input string tag);
      for (int i = 0; i < 40; i++) begin
         if (fill_cnt > fill_rd) break;
         @(negedge clk); #1;
      end
      check(fill_cnt > fill_rd && last_fill_blk == b && last_fill_data == blk_data(b), tag,
            64'(last_fill_blk), 64'(b));
      fill_rd = fill_cnt;
   endtask

   task automatic hit_miss(input logic [BA_W-1:0] b, input string tag);
      do_miss(b);
      @(negedge clk); #1;
      check(fill_valid_o && fill_blk_o == b && fill_data_o == blk_data(b), tag,
            64'(fill_blk_o), 64'(b));
      fill_rd = fill_cnt;
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      check(miss_ready_o && !l2_req_valid_o && !fill_valid_o, "R11",
            {61'd0, miss_ready_o, l2_req_valid_o, fill_valid_o}, 64'd4);
   endtask

   task automatic t_cold();
      do_miss(27'h80);
      @(negedge clk); #1;
      check(!miss_ready_o, "R1", 64'(miss_ready_o), 64'd0);
      wait_req(1'b0, 27'h80, "R1");
      respond(1'b0, 27'h80);
      wait_fill(27'h80, "R1");
      wait_req(1'b1, 27'h81, "R2");
      respond(1'b1, 27'h81);
   endtask

   task automatic t_hit();
      hit_miss(27'h81, "R3");
      wait_req(1'b1, 27'h82, "R4");
      check(req_cnt == req_rd, "R3", 64'(req_cnt), 64'(req_rd));
      respond(1'b1, 27'h82);
   endtask

   task automatic t_pending();
      do_miss(27'h83);
      wait_req(1'b0, 27'h83, "R5");
      respond(1'b0, 27'h83);
      wait_fill(27'h83, "R5");
      wait_req(1'b1, 27'h84, "R2");
      do_miss(27'h84);
      repeat (4) @(negedge clk);
      #1;
      check(req_cnt == req_rd && fill_cnt == fill_rd, "R6", 64'(req_cnt), 64'(req_rd));
      respond(1'b1, 27'h84);
      wait_fill(27'h84, "R6");
      wait_req(1'b1, 27'h85, "R4");
      respond(1'b1, 27'h85);
      do_miss(27'h82);
      wait_req(1'b0, 27'h82, "R5");
      respond(1'b0, 27'h82);
      wait_fill(27'h82, "R5");
      wait_req(1'b1, 27'h83, "R2");
      respond(1'b1, 27'h83);
   endtask

   task automatic t_priority();
      @(posedge clk); #2;
      l2_req_ready_i = 1'b0;
      do_miss(27'h200);
      @(negedge clk); #1;
      check(l2_req_valid_o && !l2_req_pf_o && l2_req_blk_o == 27'h200, "R7",
            64'(l2_req_blk_o), 64'h200);
      repeat (3) @(negedge clk);
      #1;
      check(l2_req_valid_o && !l2_req_pf_o && l2_req_blk_o == 27'h200, "R7",
            64'(l2_req_blk_o), 64'h200);
      @(posedge clk); #2;
      l2_req_ready_i = 1'b1;
      wait_req(1'b0, 27'h200, "R7");
      wait_req(1'b1, 27'h201, "R7");
      respond(1'b0, 27'h200);
      wait_fill(27'h200, "R1");
      respond(1'b1, 27'h201);
   endtask

   task automatic t_stale();
      do_miss(27'h300);
      wait_req(1'b0, 27'h300, "R1");
      respond(1'b0, 27'h300);
      wait_fill(27'h300, "R1");
      wait_req(1'b1, 27'h301, "R2");
      do_miss(27'h500);
      wait_req(1'b0, 27'h500, "R5");
      respond(1'b0, 27'h500);
      wait_fill(27'h500, "R5");
      repeat (5) @(negedge clk);
      #1;
      check(req_cnt == req_rd, "R10", 64'(req_cnt), 64'(req_rd));
      respond(1'b1, 27'h301);
      wait_req(1'b1, 27'h501, "R10");
      respond(1'b1, 27'h501);
      do_miss(27'h301);
      wait_req(1'b0, 27'h301, "R9");
      respond(1'b0, 27'h301);
      wait_fill(27'h301, "R9");
      wait_req(1'b1, 27'h302, "R2");
      respond(1'b1, 27'h302);
   endtask

   task automatic t_flush();
      @(posedge clk); #2;
      flush_i = 1'b1;
      @(posedge clk); #2;
      flush_i = 1'b0;
      do_miss(27'h302);
      wait_req(1'b0, 27'h302, "R8");
      respond(1'b0, 27'h302);
      wait_fill(27'h302, "R8");
      wait_req(1'b1, 27'h303, "R2");
      respond(1'b1, 27'h303);
   endtask

   task automatic t_wrap();
      do_miss({BA_W{1'b1}});
      wait_req(1'b0, {BA_W{1'b1}}, "R1");
      respond(1'b0, {BA_W{1'b1}});
      wait_fill({BA_W{1'b1}}, "R1");
      wait_req(1'b1, '0, "R2");
      respond(1'b1, '0);
      hit_miss('0, "R3");
      wait_req(1'b1, 27'h1, "R4");
      respond(1'b1, 27'h1);
   endtask

   initial begin
      #(20 * 20000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      t_reset();
      t_cold();
      t_hit();
      t_pending();
      t_priority();
      t_stale();
      t_flush();
      t_wrap();
      repeat (5) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule